// File: doc/BRIEF.md
# Smart-Card Answer-to-Reset Parser

This block listens passively to the byte stream a smart card sends once its reset line is released. It tracks the structure of that answer: an initial character, a format byte, the chained groups of optional interface bytes, the historical bytes and a closing check byte. It does this without decoding the card's protocol parameters. Received bytes come in with a one-cycle valid strobe. A level input reports when the card is held in reset, and while it is high the parser stays at its starting point.

For every byte it accepts, the parser raises a store strobe carrying a sequential address and the byte itself, so a 64-entry capture memory outside the block can record the answer. From the format byte it exports the historical byte count. It also exports the work-waiting integer, which keeps its default of 10 unless a third interface byte follows a fourth interface byte whose low nibble is 2. When the check byte arrives it raises a one-cycle completion pulse. After that it ignores traffic until the next card reset.

Top module: `atr_parser`

## Requirements
- R1: The chip reset (rst_n low) and a card reset (card_in_reset high, taking effect at the next clock) both bring the parser back to waiting for the initial character, with store_en and atr_done low, hist_count 0 and wi_value 10.
- R2: While the parser waits for the initial character, a byte of 0x00 is dropped: no store occurs and the address does not move. The first non-zero byte is stored at address 0.
- R3: Each accepted byte gives store_en high in the clock cycle after the byte's strobe cycle, with store_data equal to the byte and store_addr one above the previous store (0 for the first).
- R4: From the cycle after the format byte, hist_count equals that byte's bits [3:0]. It holds that value until the next reset.
- R5: After the format byte or a fourth interface byte, the next expected field is the lowest set presence bit among bits 4 (first), 5 (second), 6 (third) and 7 (fourth). After a first field the scan starts at bit 5, after a second at bit 6, and after a third only bit 7 is tested. If no bit is found, historical bytes follow.
- R6: A third interface byte is copied to wi_value only when the low nibble of the most recent fourth interface byte is 2. The format byte never counts as such a byte.
- R7: Each historical byte lowers the remaining count. When the count reaches zero the next byte is the check byte. A zero count jumps straight from the interface bytes to the check byte.
- R8: The check byte is stored and produces atr_done high for exactly one cycle, in the cycle after its strobe. Later bytes produce neither a store nor another pulse until a reset.
- R9: Once 64 bytes have been stored, further bytes of the answer produce no store, but parsing and the completion pulse continue.
- R10: A byte strobed while card_in_reset is high is neither stored nor parsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| card_in_reset | input | 1 | High while the card's reset line is asserted |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| hist_count | output | 4 | Historical byte count taken from the format byte |
| wi_value | output | 8 | Captured work-waiting integer |
| atr_done | output | 1 | One-cycle pulse after the check byte |
| store_en | output | 1 | Write strobe for the capture memory |
| store_addr | output | 6 | Capture memory address |
| store_data | output | 8 | Byte to be written |

## Verification
All results are registered. The store strobe, its address and data, the completion pulse, the historical count and the captured integer are each due in the cycle right after the byte's strobe cycle. The bench drives a byte at a falling edge, lets one rising edge capture it, and compares every output at the following falling edge, where it also drops the strobe. An idle cycle after each answer confirms that the pulse has fallen. One further byte confirms that the parser stays silent. Reset effects are checked one falling edge after card_in_reset is raised.

// File: rtl/atr_pkg.sv
package atr_pkg;
   typedef enum logic [3:0] {
      ST_TS   = 4'd0,
      ST_T0   = 4'd1,
      ST_TA   = 4'd2,
      ST_TB   = 4'd3,
      ST_TC   = 4'd4,
      ST_TD   = 4'd5,
      ST_HIST = 4'd6,
      ST_TCK  = 4'd7,
      ST_DONE = 4'd8
   } atr_state_e;
endpackage

// File: rtl/atr_field_sel.sv
module atr_field_sel
   import atr_pkg::*;
#(
   parameter int FIELDS = 4,
   parameter int POS_W  = $clog2(FIELDS)
) (
   input  logic [POS_W-1:0]  start_pos,
   input  logic [FIELDS-1:0] present,
   input  logic              hist_zero,
   output atr_state_e        next_st
);
   logic [FIELDS-1:0] hit;

   if (FIELDS != 4) begin : g_bad_fields
      $error("atr_field_sel: exactly four interface fields per group");
   end

   for (genvar gi = 0; gi < FIELDS; gi++) begin : g_hit
      assign hit[gi] = present[gi] && (start_pos <= POS_W'(gi));
   end

   // lowest qualifying field wins; otherwise historical bytes or check byte
   always_comb begin
      next_st = hist_zero ? ST_TCK : ST_HIST;
      for (int i = FIELDS - 1; i >= 0; i--) begin
         if (hit[i]) next_st = atr_state_e'(4'(ST_TA) + 4'(i));
      end
   end
endmodule

// File: rtl/atr_capture.sv
module atr_capture #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              accept,
   input  logic [DATA_W-1:0] byte_in,
   output logic              store_en,
   output logic [ADDR_W-1:0] store_addr,
   output logic [DATA_W-1:0] store_data
);
   localparam int IDX_W = ADDR_W + 1;
   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx        <= '0;
         store_en   <= 1'b0;
         store_addr <= '0;
         store_data <= '0;
      end else if (clear) begin
         idx      <= '0;
         store_en <= 1'b0;
      end else begin
         store_en <= 1'b0;
         if (accept && (idx < IDX_W'(DEPTH))) begin
            store_en   <= 1'b1;
            store_addr <= idx[ADDR_W-1:0];
            store_data <= byte_in;
            idx        <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/atr_parser.sv
module atr_parser
   import atr_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int BUF_DEPTH  = 64,
   parameter int WI_DEFAULT = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         card_in_reset,
   input  logic                         rx_valid,
   input  logic [DATA_W-1:0]            rx_byte,
   output logic [3:0]                   hist_count,
   output logic [DATA_W-1:0]            wi_value,
   output logic                         atr_done,
   output logic                         store_en,
   output logic [$clog2(BUF_DEPTH)-1:0] store_addr,
   output logic [DATA_W-1:0]            store_data
);
   localparam int ADDR_W = $clog2(BUF_DEPTH);
   localparam int NIB    = DATA_W / 2;

   if (DATA_W != 8) begin : g_bad_width
      $error("atr_parser: characters are eight bits wide");
   end
   if (BUF_DEPTH < 2 || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("atr_parser: capture depth must be a power of two");
   end
   if (WI_DEFAULT < 1 || WI_DEFAULT > 255) begin : g_bad_wi
      $error("atr_parser: default waiting integer out of range");
   end

   atr_state_e        state;
   atr_state_e        sel_next;
   logic [NIB-1:0]    hist_left;
   logic [DATA_W-1:0] last_td;
   logic [1:0]        start_pos;
   logic [NIB-1:0]    present;
   logic              hist_zero;
   logic              is_desc;
   logic              accept;

   assign is_desc = (state == ST_T0) || (state == ST_TD);
   assign accept  = rx_valid && !card_in_reset && (state != ST_DONE) &&
                    !((state == ST_TS) && (rx_byte == '0));

   always_comb begin
      case (state)
         ST_TA:   start_pos = 2'd1;
         ST_TB:   start_pos = 2'd2;
         ST_TC:   start_pos = 2'd3;
         default: start_pos = 2'd0;
      endcase
   end

   assign present   = is_desc ? rx_byte[DATA_W-1:NIB] : last_td[DATA_W-1:NIB];
   assign hist_zero = (state == ST_T0) ? (rx_byte[NIB-1:0] == '0) : (hist_left == '0);

   atr_field_sel #(.FIELDS(4)) i_field_sel (
      .start_pos (start_pos),
      .present   (present),
      .hist_zero (hist_zero),
      .next_st   (sel_next)
   );

   atr_capture #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (card_in_reset),
      .accept     (accept),
      .byte_in    (rx_byte),
      .store_en   (store_en),
      .store_addr (store_addr),
      .store_data (store_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_TS;
         hist_count <= '0;
         hist_left  <= '0;
         last_td    <= '0;
         wi_value   <= DATA_W'(WI_DEFAULT);
         atr_done   <= 1'b0;
      end else if (card_in_reset) begin
         state      <= ST_TS;
         hist_count <= '0;
         hist_left  <= '0;
         last_td    <= '0;
         wi_value   <= DATA_W'(WI_DEFAULT);
         atr_done   <= 1'b0;
      end else begin
         atr_done <= 1'b0;
         if (accept) begin
            case (state)
               ST_TS: state <= ST_T0;
               ST_T0: begin
                  hist_count <= rx_byte[NIB-1:0];
                  hist_left  <= rx_byte[NIB-1:0];
                  last_td    <= {rx_byte[DATA_W-1:NIB], {NIB{1'b0}}};
                  state      <= sel_next;
               end
               ST_TA, ST_TB: state <= sel_next;
               ST_TC: begin
                  if (last_td[NIB-1:0] == NIB'(2)) wi_value <= rx_byte;
                  state <= sel_next;
               end
               ST_TD: begin
                  last_td <= rx_byte;
                  state   <= sel_next;
               end
               ST_HIST: begin
                  hist_left <= hist_left - 1'b1;
                  if (hist_left == NIB'(1)) state <= ST_TCK;
               end
               ST_TCK: begin
                  atr_done <= 1'b1;
                  state    <= ST_DONE;
               end
               default: state <= ST_TS;
            endcase
         end
      end
   end
endmodule

// File: rtl/atr_parser_chk.sv
module atr_parser_chk #(
   parameter int DATA_W     = 8,
   parameter int BUF_DEPTH  = 64,
   parameter int WI_DEFAULT = 10
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         card_in_reset,
   input logic                         rx_valid,
   input logic [3:0]                   hist_count,
   input logic [DATA_W-1:0]            wi_value,
   input logic                         atr_done,
   input logic                         store_en,
   input logic [$clog2(BUF_DEPTH)-1:0] store_addr
);
   a_r1_card_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      card_in_reset |=> (!store_en && !atr_done && hist_count == 4'd0 &&
                         wi_value == DATA_W'(WI_DEFAULT)));

   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (store_en && !card_in_reset) |=>
         (!store_en || store_addr == $past(store_addr) + 1'b1));

   a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_valid && !card_in_reset) |=> ($stable(hist_count) && $stable(wi_value)));

   a_r8_done_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      atr_done |=> (!atr_done && !store_en));

   a_r10_no_strobe_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !store_en);
endmodule

bind atr_parser atr_parser_chk #(
   .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .WI_DEFAULT(WI_DEFAULT)
) i_atr_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .card_in_reset (card_in_reset),
   .rx_valid      (rx_valid),
   .hist_count    (hist_count),
   .wi_value      (wi_value),
   .atr_done      (atr_done),
   .store_en      (store_en),
   .store_addr    (store_addr)
);

// File: tb/test_atr_parser.sv
module test_atr_parser;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       card_in_reset = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [3:0] hist_count;
   logic [7:0] wi_value;
   logic       atr_done;
   logic       store_en;
   logic [5:0] store_addr;
   logic [7:0] store_data;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   logic [7:0] seq [96];
   int seq_len, lead_zeros, exp_hist, exp_wi;

   always #10 clk = ~clk;

   atr_parser i_atr_parser (
      .clk(clk), .rst_n(rst_n), .card_in_reset(card_in_reset),
      .rx_valid(rx_valid), .rx_byte(rx_byte),
      .hist_count(hist_count), .wi_value(wi_value), .atr_done(atr_done),
      .store_en(store_en), .store_addr(store_addr), .store_data(store_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      seq[seq_len] = b;
      seq_len++;
   endtask

   // one byte strobe; outputs sampled at the next falling edge
   task automatic send(input logic [7:0] b, input bit e_store, input int e_addr, input bit e_done,
                       input string req);
      @(negedge clk);
      rx_byte  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      chk(store_en == e_store, {req, " store_en"}, int'(store_en), int'(e_store));
      if (e_store) begin
         chk(int'(store_addr) == e_addr, {req, " store_addr"}, int'(store_addr), e_addr);
         chk(store_data == b, {req, " store_data"}, int'(store_data), int'(b));
      end
      chk(atr_done == e_done, {req, " atr_done"}, int'(atr_done), int'(e_done));
   endtask

   task automatic card_reset_pulse();
      @(negedge clk);
      card_in_reset = 1'b1;
      rx_byte  = 8'h3B;
      rx_valid = 1'b1;          // R10: byte during card reset is ignored
      @(negedge clk);
      rx_valid = 1'b0;
      chk(!store_en, "R10 store during card reset", int'(store_en), 0);
      chk(!atr_done && hist_count == 0, "R1 idle after card reset", int'(hist_count), 0);
      chk(wi_value == 8'd10, "R1 wi default", int'(wi_value), 10);
      card_in_reset = 1'b0;
   endtask

   task automatic run_seq(input string tag);
      card_reset_pulse();
      for (int i = 0; i < seq_len; i++) begin
         int  pos = i - lead_zeros;
         bit  e_st = (i >= lead_zeros) && (pos < 64);
         send(seq[i], e_st, pos, i == seq_len - 1,
              (i < lead_zeros) ? "R2" : ((pos >= 64) ? "R9" : {"R3 ", tag}));
      end
      @(negedge clk);
      chk(!atr_done, "R8 done single pulse", int'(atr_done), 0);
      chk(int'(hist_count) == exp_hist, "R4 hist_count", int'(hist_count), exp_hist);
      chk(int'(wi_value) == exp_wi, "R6 wi_value", int'(wi_value), exp_wi);
      send(8'h3B, 1'b0, 0, 1'b0, "R8 after done");
   endtask

   task automatic build(input int y1, input int kv);
      int y2, t1;
      seq_len    = 0;
      lead_zeros = kv % 2;
      for (int z = 0; z < lead_zeros; z++) push(8'h00);
      push(8'h3B);
      push(8'((y1 << 4) | kv));
      exp_hist = kv;
      exp_wi   = 10;
      y2 = ((y1 * 5 + kv) & 15) | 4;
      t1 = (kv % 2 == 0) ? 2 : 1;
      if (y1 & 1) push(8'h11);
      if (y1 & 2) push(8'h00);
      if (y1 & 4) push(8'(8'hA0 + y1));        // first-group third byte: never WI
      if (y1 & 8) begin
         push(8'((y2 << 4) | t1));
         if (y2 & 1) push(8'h22);
         if (y2 & 2) push(8'h33);
         push(8'(8'h40 + y1 + kv));
         if (t1 == 2) exp_wi = 8'h40 + y1 + kv;
         if (y2 & 8) push(8'h01);
      end
      for (int h = 0; h < kv; h++) push(8'(8'h50 + h));
      push(8'hEE);
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      chk(!store_en && !atr_done, "R1 chip reset outputs", int'(store_en), 0);
      chk(wi_value == 8'd10 && hist_count == 0, "R1 chip reset fields", int'(wi_value), 10);
      rst_n = 1'b1;

      // R5 R6 R7: sweep of format presence bits and historical counts
      for (int y1 = 0; y1 < 16; y1++) begin
         for (int k = 0; k < 4; k++) begin
            build(y1, (k == 3) ? 15 : k);
            run_seq(((k == 0) ? "R7" : "R5"));
         end
      end

      // R1: reset in the middle of an answer restarts the address at 0
      card_reset_pulse();
      send(8'h3B, 1'b1, 0, 1'b0, "R3");
      send(8'h95, 1'b1, 1, 1'b0, "R4");
      chk(hist_count == 4'd5, "R4 hist mid", int'(hist_count), 5);
      build(9, 2);
      run_seq("R1");

      // R9: answer longer than the capture memory
      seq_len = 0; lead_zeros = 0; exp_hist = 15; exp_wi = 10;
      push(8'h3B); push(8'hFF);
      for (int g = 0; g < 14; g++) begin
         push(8'h11); push(8'h22); push(8'h33);
         push((g < 13) ? 8'hF0 : 8'h00);
      end
      for (int h = 0; h < 15; h++) push(8'(8'h60 + h));
      push(8'hEE);
      run_seq("R9");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule